// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a chain of 64-bit descriptors from translation tables held in memory. A lookup carries the virtual address together with the configuration of both translation regions. The lower region covers addresses whose upper bits are all zero. The upper region covers addresses whose upper bits are all one. Each region has its own table base, its own address width (25 to 48 bits) and its own granule, which is either 4 KB or 64 KB.

First the walker decides which region the address falls in. It then rejects any address that lies in the unmapped hole between the two regions. When tagging is on, the top byte of the address is dropped before any of this. After that it walks from the first table level that the region's width and granule call for, down to a block or page descriptor. It reads memory over a plain request/response port and keeps at most one read in flight. A lookup ends with a one-cycle completion pulse. That pulse carries either the physical address and the two attribute fields of the final descriptor, or a fault with the level where the walk stopped.

Top module: `ttw_walker`

## Requirements
- R1: The region is chosen by address bit 63, or by bit 55 when `tag_en` is 1. A value of 0 selects `base_lo`/`size_lo`/`gran_lo` and a value of 1 selects `base_hi`/`size_hi`/`gran_hi`. Granule code 0 means 4 KB and code 1 means 64 KB.
- R2: Take N as the selected region's size. For the lower region, every checked address bit from N up to bit 63 must be 0. For the upper region, every checked bit must be 1. Any other address completes with `done_fault`=1, `done_gap`=1 and `done_level`=0, and issues no memory read. An address that passes this check never sets `done_gap`.
- R3: With `tag_en`=1, bits 63:56 take no part in the hole check or in translation. With `tag_en`=0 they are checked like every other upper bit.
- R4: With the 4 KB granule the page offset is bits 11:0. Each level uses 9 index bits, and level L indexes bits starting at 12+9*(3-L). The walk starts at level 0 if N>39, level 1 if N>30, level 2 if N>21, and level 3 otherwise.
- R5: With the 64 KB granule the page offset is bits 15:0. Each level uses 13 index bits starting at 16+13*(3-L). The walk starts at level 1 if N>42, level 2 if N>29, and level 3 otherwise. When N is 48 the top table is indexed by only 6 bits.
- R6: A level reads the descriptor at the table address plus 8 times its index. A descriptor with bit 0 clear ends the walk with `done_fault`=1, `done_gap`=0 and `done_level` set to that level.
- R7: Below level 3, a valid descriptor with bit 1 set points to the next table. That table's address is descriptor bits 47:0 with the granule offset bits cleared. A valid descriptor with bit 1 clear is a block. Its physical address takes descriptor bits above the level's index start and address bits below it.
- R8: At level 3 a valid descriptor must have bit 1 set, in which case it is a page. With bit 1 clear the walk faults at level 3.
- R9: A successful walk returns `done_pa`, `done_upper` = descriptor bits 63:52, `done_lower` = descriptor bits 11:2 and `done_level` = the final level. `done_valid` is high for exactly one cycle. A faulting walk returns zero in `done_pa`, `done_upper` and `done_lower`.
- R10: `mem_req_valid` is a one-cycle pulse, and no new read is issued until the previous response has come back. `req_ready` is high only while idle. A request presented while a walk is running is ignored.
- R11: During reset, and after reset is released, the block is idle: `req_ready`=1, `mem_req_valid`=0 and `done_valid`=0. A reset in the middle of a walk abandons that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Walker idle; a request is taken |
| req_va | input | 64 | Virtual address |
| tag_en | input | 1 | Ignore top address byte |
| base_lo | input | AW | Lower region table base |
| base_hi | input | AW | Upper region table base |
| size_lo | input | 6 | Lower region address width N |
| size_hi | input | 6 | Upper region address width N |
| gran_lo | input | 1 | Lower region granule (0: 4 KB, 1: 64 KB) |
| gran_hi | input | 1 | Upper region granule (0: 4 KB, 1: 64 KB) |
| mem_req_valid | output | 1 | Descriptor read pulse |
| mem_req_addr | output | AW | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Descriptor |
| done_valid | output | 1 | Lookup complete pulse |
| done_fault | output | 1 | Translation fault |
| done_gap | output | 1 | Fault caused by the unmapped hole |
| done_level | output | 2 | Final or faulting level |
| done_pa | output | AW | Physical address |
| done_upper | output | 12 | Upper attribute field |
| done_lower | output | 10 | Lower attribute field |

## Verification
The walk is driven through every starting level in both granules. The cases are four 4 KB levels, three 4 KB levels from a narrower region, three 64 KB levels with the partial top table, and two 64 KB levels. Together they show whether index positions, start levels and table chaining are right for each geometry. Block descriptors at two different levels and pages with set attribute bits separate the block and page offset splits. Missing entries at level 0 and level 2, and a page slot with bit 1 clear, separate the two fault causes and their reported levels. Addresses just outside each region, with and without tagging, tell hole faults apart from walk faults, and a request raised mid-walk, a slow memory and a reset mid-walk exercise the one-read-at-a-time control.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  localparam int unsigned DESC_W     = 64;
  localparam int unsigned OFF_SMALL  = 12;
  localparam int unsigned IDXW_SMALL = 9;
  localparam int unsigned OFF_LARGE  = 16;
  localparam int unsigned IDXW_LARGE = 13;
  localparam int unsigned IDXW_MAX   = IDXW_LARGE;
  localparam logic [1:0]  LVL_LAST   = 2'd3;

  typedef enum logic {
    GRAN_SMALL = 1'b0,
    GRAN_LARGE = 1'b1
  } gran_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_e;
endpackage

// File: rtl/ttw_region.sv
module ttw_region
  import ttw_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  logic [63:0]   va,
  input  logic          tag_en,
  input  logic [AW-1:0] base_lo,
  input  logic [AW-1:0] base_hi,
  input  logic [5:0]    size_lo,
  input  logic [5:0]    size_hi,
  input  logic          gran_lo,
  input  logic          gran_hi,
  output logic          gap,
  output logic [AW-1:0] eff_va,
  output logic [AW-1:0] base,
  output gran_e         gran,
  output logic [1:0]    start_lvl
);
  logic        sel_hi;
  logic [5:0]  width;
  logic [63:0] keep_mask;
  logic [63:0] chk_mask;

  always_comb begin
    sel_hi    = tag_en ? va[55] : va[63];
    width     = sel_hi ? size_hi : size_lo;
    gran      = gran_e'(sel_hi ? gran_hi : gran_lo);
    base      = sel_hi ? base_hi : base_lo;
    keep_mask = (64'd1 << width) - 64'd1;
    chk_mask  = ~keep_mask;
    if (tag_en) chk_mask[63:56] = 8'h00;
    gap       = sel_hi ? ((va & chk_mask) != chk_mask) : ((va & chk_mask) != 64'd0);
    eff_va    = va[AW-1:0] & keep_mask[AW-1:0];
  end

  // first level follows from how many index bits the width leaves above the page offset
  always_comb begin
    if (gran == GRAN_LARGE) begin
      if (width > 6'd42)      start_lvl = 2'd1;
      else if (width > 6'd29) start_lvl = 2'd2;
      else                    start_lvl = 2'd3;
    end else begin
      if (width > 6'd39)      start_lvl = 2'd0;
      else if (width > 6'd30) start_lvl = 2'd1;
      else if (width > 6'd21) start_lvl = 2'd2;
      else                    start_lvl = 2'd3;
    end
  end
endmodule

// File: rtl/ttw_geom.sv
module ttw_geom
  import ttw_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  gran_e         gran,
  input  logic [1:0]    lvl,
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] table_base,
  input  logic [AW-1:0] desc_addr_field,
  output logic [AW-1:0] desc_addr,
  output logic [AW-1:0] next_table,
  output logic [AW-1:0] leaf_pa
);
  localparam int unsigned PAD_W = AW - IDXW_MAX - 3;

  logic [1:0]          steps;
  logic [6:0]          low_bit;
  logic [6:0]          off_bits;
  logic [6:0]          idx_bits;
  logic [IDXW_MAX-1:0] idx_mask;
  logic [IDXW_MAX-1:0] index;
  logic [AW-1:0]       off_mask;
  logic [AW-1:0]       blk_mask;

  always_comb begin
    steps = LVL_LAST - lvl;
    if (gran == GRAN_LARGE) begin
      off_bits = 7'(OFF_LARGE);
      idx_bits = 7'(IDXW_LARGE);
    end else begin
      off_bits = 7'(OFF_SMALL);
      idx_bits = 7'(IDXW_SMALL);
    end
    low_bit   = off_bits + idx_bits * {5'd0, steps};
    idx_mask  = IDXW_MAX'((1 << idx_bits) - 1);
    index     = IDXW_MAX'(va >> low_bit) & idx_mask;
    desc_addr = table_base + {{PAD_W{1'b0}}, index, 3'b000};
    off_mask  = (AW'(1) << off_bits) - AW'(1);
    next_table = desc_addr_field & ~off_mask;
    if (low_bit >= 7'(AW)) blk_mask = '1;
    else                   blk_mask = (AW'(1) << low_bit) - AW'(1);
    leaf_pa = (desc_addr_field & ~blk_mask) | (va & blk_mask);
  end
endmodule

// File: rtl/ttw_walker.sv
module ttw_walker
  import ttw_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [63:0]   req_va,
  input  logic          tag_en,
  input  logic [AW-1:0] base_lo,
  input  logic [AW-1:0] base_hi,
  input  logic [5:0]    size_lo,
  input  logic [5:0]    size_hi,
  input  logic          gran_lo,
  input  logic          gran_hi,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data,
  output logic          done_valid,
  output logic          done_fault,
  output logic          done_gap,
  output logic [1:0]    done_level,
  output logic [AW-1:0] done_pa,
  output logic [11:0]   done_upper,
  output logic [9:0]    done_lower
);
  walk_st_e      st_q, st_d;
  logic [AW-1:0] va_q, va_d;
  gran_e         gran_q, gran_d;
  logic [1:0]    lvl_q, lvl_d;
  logic [AW-1:0] tbl_q, tbl_d;
  logic          walk_en;

  logic          fin;
  logic          f_fault, f_gap;
  logic [1:0]    f_lvl;
  logic [AW-1:0] f_pa;
  logic [11:0]   f_up;
  logic [9:0]    f_lo;

  logic          rg_gap;
  logic [AW-1:0] rg_eff, rg_base;
  gran_e         rg_gran;
  logic [1:0]    rg_start;
  logic [AW-1:0] g_addr, g_next, g_leaf;

  logic          done_valid_q, done_fault_q, done_gap_q;
  logic [1:0]    done_level_q;
  logic [AW-1:0] done_pa_q;
  logic [11:0]   done_upper_q;
  logic [9:0]    done_lower_q;

  logic          unused_rsv;
  assign unused_rsv = ^mem_rsp_data[DESC_W-13:AW];

  ttw_region #(.AW(AW)) u_region (
    .va        (req_va),
    .tag_en    (tag_en),
    .base_lo   (base_lo),
    .base_hi   (base_hi),
    .size_lo   (size_lo),
    .size_hi   (size_hi),
    .gran_lo   (gran_lo),
    .gran_hi   (gran_hi),
    .gap       (rg_gap),
    .eff_va    (rg_eff),
    .base      (rg_base),
    .gran      (rg_gran),
    .start_lvl (rg_start)
  );

  ttw_geom #(.AW(AW)) u_geom (
    .gran            (gran_q),
    .lvl             (lvl_q),
    .va              (va_q),
    .table_base      (tbl_q),
    .desc_addr_field (mem_rsp_data[AW-1:0]),
    .desc_addr       (g_addr),
    .next_table      (g_next),
    .leaf_pa         (g_leaf)
  );

  always_comb begin
    st_d    = st_q;
    va_d    = va_q;
    gran_d  = gran_q;
    lvl_d   = lvl_q;
    tbl_d   = tbl_q;
    walk_en = 1'b0;
    fin     = 1'b0;
    f_fault = 1'b0;
    f_gap   = 1'b0;
    f_lvl   = lvl_q;
    f_pa    = '0;
    f_up    = '0;
    f_lo    = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (rg_gap) begin
            fin     = 1'b1;
            f_fault = 1'b1;
            f_gap   = 1'b1;
            f_lvl   = 2'd0;
          end else begin
            walk_en = 1'b1;
            va_d    = rg_eff;
            gran_d  = rg_gran;
            lvl_d   = rg_start;
            tbl_d   = rg_base;
            st_d    = ST_READ;
          end
        end
      end
      ST_READ: st_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            fin     = 1'b1;
            f_fault = 1'b1;
            st_d    = ST_IDLE;
          end else if ((lvl_q != LVL_LAST) && mem_rsp_data[1]) begin
            walk_en = 1'b1;
            tbl_d   = g_next;
            lvl_d   = lvl_q + 2'd1;
            st_d    = ST_READ;
          end else if ((lvl_q == LVL_LAST) && !mem_rsp_data[1]) begin
            fin     = 1'b1;
            f_fault = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            fin  = 1'b1;
            f_pa = g_leaf;
            f_up = mem_rsp_data[DESC_W-1:DESC_W-12];
            f_lo = mem_rsp_data[11:2];
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      done_valid_q <= 1'b0;
    end else begin
      st_q         <= st_d;
      done_valid_q <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      gran_q <= GRAN_SMALL;
      lvl_q  <= 2'd0;
      tbl_q  <= '0;
    end else if (walk_en) begin
      va_q   <= va_d;
      gran_q <= gran_d;
      lvl_q  <= lvl_d;
      tbl_q  <= tbl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_fault_q <= 1'b0;
      done_gap_q   <= 1'b0;
      done_level_q <= 2'd0;
      done_pa_q    <= '0;
      done_upper_q <= '0;
      done_lower_q <= '0;
    end else if (fin) begin
      done_fault_q <= f_fault;
      done_gap_q   <= f_gap;
      done_level_q <= f_lvl;
      done_pa_q    <= f_pa;
      done_upper_q <= f_up;
      done_lower_q <= f_lo;
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_READ);
  assign mem_req_addr  = g_addr;
  assign done_valid    = done_valid_q;
  assign done_fault    = done_fault_q;
  assign done_gap      = done_gap_q;
  assign done_level    = done_level_q;
  assign done_pa       = done_pa_q;
  assign done_upper    = done_upper_q;
  assign done_lower    = done_lower_q;
endmodule

// File: rtl/ttw_walker_chk.sv
module ttw_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       mem_req_valid,
  input logic       done_valid,
  input logic       done_fault,
  input logic       done_gap,
  input logic [1:0] done_level
);
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R10

  AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R9

  AST_GAP_IS_LEVEL0_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_gap) |-> (done_fault && (done_level == 2'd0))); // R2

  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> req_ready); // R10
endmodule

bind ttw_walker ttw_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .done_valid    (done_valid),
  .done_fault    (done_fault),
  .done_gap      (done_gap),
  .done_level    (done_level)
);

// File: tb/ttw_walker_test.sv
module ttw_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;

  typedef struct packed {
    logic [63:0] va;
    logic        tag;
    logic [5:0]  n_lo;
    logic        g_lo;
    logic [5:0]  n_hi;
    logic        g_hi;
    logic        fault;
    logic        gap;
    logic [1:0]  lvl;
    logic [47:0] pa;
    logic [11:0] up;
    logic [9:0]  lo;
    logic [3:0]  reads;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0080_8060_4ABC, 1'b0, 6'd48, 1'b0, 6'd42, 1'b1, 1'b0, 1'b0, 2'd3, 48'h0000_7654_3ABC, 12'h00C, 10'h3D1, 4'd4},
    '{64'h0000_0081_5234_5678, 1'b0, 6'd48, 1'b0, 6'd42, 1'b1, 1'b0, 1'b0, 2'd1, 48'h0000_D234_5678, 12'h000, 10'h100, 4'd2},
    '{64'h0000_0080_80E0_0000, 1'b0, 6'd48, 1'b0, 6'd42, 1'b1, 1'b1, 1'b0, 2'd2, 48'h0,              12'h000, 10'h000, 4'd3},
    '{64'h0000_0080_8060_9000, 1'b0, 6'd48, 1'b0, 6'd42, 1'b1, 1'b1, 1'b0, 2'd3, 48'h0,              12'h000, 10'h000, 4'd4},
    '{64'h0001_0000_0000_0000, 1'b0, 6'd48, 1'b0, 6'd42, 1'b1, 1'b1, 1'b1, 2'd0, 48'h0,              12'h000, 10'h000, 4'd0},
    '{64'h5A00_0080_8060_4ABC, 1'b1, 6'd48, 1'b0, 6'd42, 1'b1, 1'b0, 1'b0, 2'd3, 48'h0000_7654_3ABC, 12'h00C, 10'h3D1, 4'd4},
    '{64'h5A00_0080_8060_4ABC, 1'b0, 6'd48, 1'b0, 6'd42, 1'b1, 1'b1, 1'b1, 2'd0, 48'h0,              12'h000, 10'h000, 4'd0},
    '{64'hFFFF_FC00_2002_1234, 1'b0, 6'd48, 1'b0, 6'd42, 1'b1, 1'b0, 1'b0, 2'd3, 48'h0000_ABCD_1234, 12'h000, 10'h000, 4'd2},
    '{64'hFFFF_0C00_0001_0042, 1'b0, 6'd48, 1'b0, 6'd48, 1'b1, 1'b0, 1'b0, 2'd3, 48'h0000_0777_0042, 12'h000, 10'h000, 4'd3},
    '{64'hFFFF_FC00_4ABC_DEF0, 1'b0, 6'd48, 1'b0, 6'd42, 1'b1, 1'b0, 1'b0, 2'd2, 48'h0000_6ABC_DEF0, 12'h000, 10'h000, 4'd1},
    '{64'hFFFF_0000_0000_0000, 1'b0, 6'd48, 1'b0, 6'd42, 1'b1, 1'b1, 1'b1, 2'd0, 48'h0,              12'h000, 10'h000, 4'd0},
    '{64'h0000_0000_8060_4ABC, 1'b0, 6'd39, 1'b0, 6'd42, 1'b1, 1'b0, 1'b0, 2'd3, 48'h0000_7654_3ABC, 12'h00C, 10'h3D1, 4'd3},
    '{64'h0000_0080_0000_0000, 1'b0, 6'd39, 1'b0, 6'd42, 1'b1, 1'b1, 1'b1, 2'd0, 48'h0,              12'h000, 10'h000, 4'd0},
    '{64'h0000_FFFF_FFFF_FFFF, 1'b0, 6'd48, 1'b0, 6'd42, 1'b1, 1'b1, 1'b0, 2'd0, 48'h0,              12'h000, 10'h000, 4'd1},
    '{64'h3CFF_FC00_2002_1234, 1'b1, 6'd48, 1'b0, 6'd42, 1'b1, 1'b0, 1'b0, 2'd3, 48'h0000_ABCD_1234, 12'h000, 10'h000, 4'd2}
  };

  // requirement each vector targets
  string vtag [NV] = '{
    "R4 R9", "R7 block L1", "R6 invalid L2", "R8 page bit", "R2 low hole",
    "R3 tag on", "R3 tag off", "R1 R5 upper", "R5 partial top", "R7 block L2",
    "R2 upper hole", "R4 start L1", "R2 N39 hole", "R2 low edge", "R3 R1 tag upper"
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [63:0]   req_va = '0;
  logic          tag_en = 1'b0;
  logic [AW-1:0] base_lo = 48'h0000_0001_0000;
  logic [AW-1:0] base_hi = 48'h0000_0020_0000;
  logic [5:0]    size_lo = 6'd48;
  logic [5:0]    size_hi = 6'd42;
  logic          gran_lo = 1'b0;
  logic          gran_hi = 1'b1;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [63:0]   mem_rsp_data = '0;
  logic          done_valid, done_fault, done_gap;
  logic [1:0]    done_level;
  logic [AW-1:0] done_pa;
  logic [11:0]   done_upper;
  logic [9:0]    done_lower;

  int checks = 0;
  int fails = 0;
  int reads = 0;
  int overlaps = 0;
  int rsp_delay = 0;
  int cnt = 0;
  logic pend = 1'b0;
  logic [AW-1:0] pend_addr = '0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ttw_walker #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .tag_en(tag_en), .base_lo(base_lo), .base_hi(base_hi),
    .size_lo(size_lo), .size_hi(size_hi), .gran_lo(gran_lo), .gran_hi(gran_hi),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault), .done_gap(done_gap),
    .done_level(done_level), .done_pa(done_pa), .done_upper(done_upper),
    .done_lower(done_lower)
  );

  function automatic logic [63:0] mem_rd(input logic [AW-1:0] a);
    case (a)
      48'h0000_0001_0008: mem_rd = 64'h0000_0000_0001_1003;
      48'h0000_0001_0010: mem_rd = 64'h0000_0000_0001_2003;
      48'h0000_0001_1010: mem_rd = 64'h0000_0000_0001_2003;
      48'h0000_0001_1028: mem_rd = 64'h0000_0000_C000_0401;
      48'h0000_0001_2018: mem_rd = 64'h0000_0000_0001_3003;
      48'h0000_0001_3020: mem_rd = 64'h00C0_0000_7654_3F47;
      48'h0000_0001_3048: mem_rd = 64'h0000_0000_0000_0001;
      48'h0000_0020_0008: mem_rd = 64'h0000_0000_0030_0003;
      48'h0000_0020_0010: mem_rd = 64'h0000_0000_6000_0001;
      48'h0000_0020_0018: mem_rd = 64'h0000_0000_0040_0003;
      48'h0000_0030_0010: mem_rd = 64'h0000_0000_ABCD_0003;
      48'h0000_0040_0000: mem_rd = 64'h0000_0000_0041_0003;
      48'h0000_0041_0008: mem_rd = 64'h0000_0000_0777_0003;
      default:            mem_rd = 64'h0;
    endcase
  endfunction

  // memory model: answers each read after rsp_delay idle cycles
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid) begin
      reads <= reads + 1;
      if (pend) overlaps <= overlaps + 1;
      pend      <= 1'b1;
      pend_addr <= mem_req_addr;
      cnt       <= rsp_delay;
    end else if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_rd(pend_addr);
        pend          <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input vec_t v);
    @(negedge clk);
    req_va = v.va; tag_en = v.tag;
    size_lo = v.n_lo; gran_lo = v.g_lo; size_hi = v.n_hi; gran_hi = v.g_hi;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input int k);
    bit seen;
    vec_t v;
    logic [87:0] act, exp;
    v = VECS[k];
    @(negedge clk);
    reads = 0;
    send(v);
    wait_done(seen);
    act = {done_fault, done_gap, done_level, done_pa, done_upper, done_lower, 4'(reads), 10'd0};
    exp = {v.fault, v.gap, v.lvl, v.pa, v.up, v.lo, v.reads, 10'd0};
    check(seen, vtag[k], {127'd0, seen}, 128'd1);
    check(act == exp, vtag[k], {40'd0, act}, {40'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    // R11: idle outputs while held in reset
    #(CLK_PERIOD * 3);
    check(req_ready && !mem_req_valid && !done_valid, "R11 in reset",
          {125'd0, req_ready, mem_req_valid, done_valid}, 128'd4);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_req_valid && !done_valid, "R11 after reset",
          {125'd0, req_ready, mem_req_valid, done_valid}, 128'd4);

    for (int k = 0; k < NV; k++) run_vec(k);

    // R9: completion pulse lasts one cycle
    send(VECS[0]);
    wait_done(seen);
    @(negedge clk);
    check(!done_valid, "R9 pulse", {127'd0, done_valid}, 128'd0);

    // R10: a request raised during a walk is ignored; slow memory
    rsp_delay = 3;
    reads = 0;
    send(VECS[0]);
    @(negedge clk);
    check(!req_ready, "R10 busy", {127'd0, req_ready}, 128'd0);
    req_va = VECS[4].va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(seen);
    check(seen && !done_fault && done_pa == VECS[0].pa && reads == 4, "R10 ignored request",
          {78'd0, done_fault, done_pa, 1'b0}, {79'd0, VECS[0].pa, 1'b0});
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done_valid) seen = 1'b1;
    end
    check(!seen, "R10 no second result", {127'd0, seen}, 128'd0);
    check(overlaps == 0, "R10 one outstanding", 128'(overlaps), 128'd0);
    rsp_delay = 0;

    // R11: reset during a walk abandons it
    send(VECS[0]);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(req_ready && !mem_req_valid && !done_valid, "R11 mid-walk reset",
          {125'd0, req_ready, mem_req_valid, done_valid}, 128'd4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_vec(7);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule